// File: doc/BRIEF.md
# Per-Thread Fetch Status Controller

This block keeps the fetch status of every hardware thread in a multithreaded front end and advances it once per clock. Each cycle it takes block and unblock pulses from four downstream stages (decode, rename, execute, commit), squash indications from decode and from commit, a flag from the reorder buffer saying a squash is still in progress, and events from the line-fetch logic. These events are request sent, request refused, retry sent, response returned, fetch fault, quiesce and fetch opportunity. All updates for a thread happen on one clock edge, and the highest-priority condition present in that cycle decides the outcome.

The block reports each thread's status as a 4-bit code and raises a stage-active flag while any enabled thread can make progress. On every squash that carries a target it also gives a per-thread redirect address with a one-cycle valid strobe. A single shared retry slot records which thread had its line request refused. While that slot is held, the line-fetch logic must not send a new request. All pins are plain control and status. No pin carries a data stream, so there is no valid/ready handshake and no back-pressure.

Top module: `fetch_status_ctrl`

## Requirements
- R1: After reset every thread is Running (code 0), the retry slot is free, no redirect strobe is raised and every redirect address is 0.
- R2: Each of the four stages has a sticky stall flag per thread. A block pulse sets it and an unblock pulse clears it. The update takes effect in the same cycle as the status decision. An unblock is legal only when the flag is set and no block arrives for that stage and thread in the same cycle.
- R3: A commit squash has top priority. On the next edge the thread is Squashing (code 2), its redirect address holds the commit target and its redirect strobe is high for one cycle.
- R4: If commit does not squash and the reorder-buffer flag is high, the thread enters or stays in Squashing, and its redirect address and strobe are not changed.
- R5: A decode squash moves a thread that is not Squashing into Squashing and loads the decode target with a strobe. In a thread that is already Squashing, a decode squash loads nothing.
- R6: With any stall flag set, the thread goes to Blocked (code 3), unless it is in WaitResponse (4), WaitRetry (5), Idle (1), TrapPending (7) or QuiescePending (8).
- R7: A thread in Blocked or Squashing that gets no squash and has no stall flag set returns to Running.
- R8: From Running, request sent gives WaitResponse. Request refused gives WaitRetry and claims the retry slot, recording the thread as owner. A retry sent while the slot is held moves the owner to WaitResponse and frees the slot.
- R9: A response in WaitResponse gives AccessComplete (code 6), or Blocked if a stall flag is set. A response in any other state has no effect.
- R10: AccessComplete stays until the thread's fetch opportunity, which makes it Running.
- R11: Any squash cancels an outstanding wait, so a response that comes back later is ignored. A squash also frees the retry slot when the squashed thread owns it. A squash of a different thread leaves the slot as it is.
- R12: A fetch fault gives TrapPending and a quiesce gives QuiescePending. Both states ignore stalls, responses and fetch opportunities and are left only through a squash.
- R13: The stage is active exactly when some thread with its enable bit set is Running, Squashing or AccessComplete.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| thr_active | input | NUM_THREADS | Thread enable mask used for the stage-active flag |
| blk_dec | input | NUM_THREADS | Decode block pulse per thread |
| unblk_dec | input | NUM_THREADS | Decode unblock pulse per thread |
| blk_ren | input | NUM_THREADS | Rename block pulse per thread |
| unblk_ren | input | NUM_THREADS | Rename unblock pulse per thread |
| blk_exe | input | NUM_THREADS | Execute block pulse per thread |
| unblk_exe | input | NUM_THREADS | Execute unblock pulse per thread |
| blk_cmt | input | NUM_THREADS | Commit block pulse per thread |
| unblk_cmt | input | NUM_THREADS | Commit unblock pulse per thread |
| cmt_squash | input | NUM_THREADS | Commit squash per thread |
| cmt_pc | input | NUM_THREADS*PC_W | Commit squash target, thread t at bits t*PC_W |
| rob_squashing | input | NUM_THREADS | Reorder buffer still squashing |
| dec_squash | input | NUM_THREADS | Decode squash per thread |
| dec_pc | input | NUM_THREADS*PC_W | Decode squash target |
| line_req_sent | input | NUM_THREADS | Line request accepted by the cache |
| line_req_refused | input | NUM_THREADS | Line request refused by the cache |
| retry_sent | input | 1 | Refused request re-sent and accepted |
| line_resp | input | NUM_THREADS | Line response returned |
| line_fault | input | NUM_THREADS | Fetch fault detected |
| line_quiesce | input | NUM_THREADS | Quiesce instruction fetched |
| fetch_grant | input | NUM_THREADS | Thread's fetch opportunity this cycle |
| thr_status | output | NUM_THREADS*4 | Status code per thread |
| stage_active | output | 1 | Some enabled thread can progress |
| redirect_valid | output | NUM_THREADS | One-cycle strobe when a redirect target is loaded |
| redirect_pc | output | NUM_THREADS*PC_W | Latest redirect target per thread |
| retry_busy | output | 1 | Retry slot held |
| retry_owner | output | TID_W | Thread owning the retry slot |

## Verification
Squash sources are applied together with stalls and the reorder-buffer flag, so the priority order can be read from the final state and redirect target. Stalls are applied in each wait, trap and quiesce state, which shows which states absorb them. Responses are returned after a squash and outside WaitResponse, which shows that a cancelled or stray response is dropped. Retry-slot tests squash the owner and, separately, a different thread, which shows that only the owner's squash frees the slot.

// File: rtl/fsc_pkg.sv
package fsc_pkg;
  localparam int STATE_W    = 4;
  localparam int NUM_STAGES = 4;

  typedef enum logic [STATE_W-1:0] {
    TS_RUN     = 4'd0,
    TS_IDLE    = 4'd1,
    TS_SQUASH  = 4'd2,
    TS_BLOCK   = 4'd3,
    TS_WRESP   = 4'd4,
    TS_WRETRY  = 4'd5,
    TS_DONE    = 4'd6,
    TS_TRAP    = 4'd7,
    TS_QUIESCE = 4'd8
  } thr_state_e;

  // states in which a stall flag does not force Blocked
  function automatic logic stall_immune(input thr_state_e s);
    return (s == TS_WRESP) || (s == TS_WRETRY) || (s == TS_IDLE) ||
           (s == TS_TRAP)  || (s == TS_QUIESCE);
  endfunction

  // states that let the stage make progress
  function automatic logic can_progress(input logic [STATE_W-1:0] s);
    return (s == TS_RUN) || (s == TS_SQUASH) || (s == TS_DONE);
  endfunction
endpackage

// File: rtl/fsc_stall_flags.sv
module fsc_stall_flags
  import fsc_pkg::*;
#(
  parameter int NUM_THREADS = 2
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic [NUM_STAGES-1:0][NUM_THREADS-1:0] blk,
  input  logic [NUM_STAGES-1:0][NUM_THREADS-1:0] unblk,
  output logic [NUM_STAGES-1:0][NUM_THREADS-1:0] flags_q,
  output logic [NUM_THREADS-1:0]                 stall_now
);
  logic [NUM_STAGES-1:0][NUM_THREADS-1:0] flags_d;

  for (genvar s = 0; s < NUM_STAGES; s++) begin : g_stage
    assign flags_d[s] = (flags_q[s] | blk[s]) & ~unblk[s];
  end

  always_comb begin
    stall_now = '0;
    for (int s = 0; s < NUM_STAGES; s++) stall_now = stall_now | flags_d[s];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= flags_d;
  end
endmodule

// File: rtl/fsc_retry_slot.sv
module fsc_retry_slot #(
  parameter int NUM_THREADS = 2,
  localparam int TID_W = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUM_THREADS-1:0] claim,
  input  logic [NUM_THREADS-1:0] squashed,
  input  logic                   retry_sent,
  output logic                   busy,
  output logic [TID_W-1:0]       owner,
  output logic [NUM_THREADS-1:0] retry_go
);
  logic             owner_squashed;
  logic [TID_W-1:0] pick;

  always_comb begin
    retry_go       = '0;
    owner_squashed = 1'b0;
    pick           = '0;
    for (int t = 0; t < NUM_THREADS; t++) begin
      if (owner == TID_W'(t)) begin
        retry_go[t]    = busy & retry_sent;
        owner_squashed = squashed[t];
      end
    end
    for (int t = NUM_THREADS - 1; t >= 0; t--)
      if (claim[t]) pick = TID_W'(t);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      owner <= '0;
    end else if (busy) begin
      if (retry_sent || owner_squashed) busy <= 1'b0;
    end else if (|claim) begin
      busy  <= 1'b1;
      owner <= pick;
    end
  end
endmodule

// File: rtl/fsc_thread_fsm.sv
module fsc_thread_fsm
  import fsc_pkg::*;
#(
  parameter int PC_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmt_sq,
  input  logic [PC_W-1:0]    cmt_tgt,
  input  logic               rob_sq,
  input  logic               dec_sq,
  input  logic [PC_W-1:0]    dec_tgt,
  input  logic               stall_now,
  input  logic               req_sent,
  input  logic               req_refused,
  input  logic               retry_go,
  input  logic               resp,
  input  logic               fault,
  input  logic               quiesce,
  input  logic               grant,
  output logic [STATE_W-1:0] state,
  output logic               redir_valid,
  output logic [PC_W-1:0]    redir_pc,
  output logic               squashed,
  output logic               claim
);
  thr_state_e      st_q, st_d;
  logic [PC_W-1:0] pc_d;
  logic            rv_d;

  always_comb begin
    st_d     = st_q;
    pc_d     = redir_pc;
    rv_d     = 1'b0;
    squashed = 1'b0;
    claim    = 1'b0;
    if (cmt_sq) begin
      st_d = TS_SQUASH; pc_d = cmt_tgt; rv_d = 1'b1; squashed = 1'b1;
    end else if (rob_sq) begin
      st_d = TS_SQUASH; squashed = 1'b1;
    end else if (dec_sq && st_q != TS_SQUASH) begin
      st_d = TS_SQUASH; pc_d = dec_tgt; rv_d = 1'b1; squashed = 1'b1;
    end else if (stall_now && !stall_immune(st_q)) begin
      st_d = TS_BLOCK;
    end else if (st_q == TS_BLOCK || st_q == TS_SQUASH) begin
      st_d = TS_RUN;
    end else begin
      unique case (st_q)
        TS_RUN: begin
          if (fault)            st_d = TS_TRAP;
          else if (quiesce)     st_d = TS_QUIESCE;
          else if (req_refused) begin st_d = TS_WRETRY; claim = 1'b1; end
          else if (req_sent)    st_d = TS_WRESP;
        end
        TS_WRESP:  if (resp)     st_d = stall_now ? TS_BLOCK : TS_DONE;
        TS_WRETRY: if (retry_go) st_d = TS_WRESP;
        TS_DONE:   if (grant)    st_d = TS_RUN;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q        <= TS_RUN;
      redir_pc    <= '0;
      redir_valid <= 1'b0;
    end else begin
      st_q        <= st_d;
      redir_pc    <= pc_d;
      redir_valid <= rv_d;
    end
  end

  assign state = st_q;
endmodule

// File: rtl/fetch_status_ctrl.sv
module fetch_status_ctrl
  import fsc_pkg::*;
#(
  parameter int NUM_THREADS = 2,
  parameter int PC_W = 32,
  localparam int TID_W = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [NUM_THREADS-1:0]         thr_active,
  input  logic [NUM_THREADS-1:0]         blk_dec,
  input  logic [NUM_THREADS-1:0]         unblk_dec,
  input  logic [NUM_THREADS-1:0]         blk_ren,
  input  logic [NUM_THREADS-1:0]         unblk_ren,
  input  logic [NUM_THREADS-1:0]         blk_exe,
  input  logic [NUM_THREADS-1:0]         unblk_exe,
  input  logic [NUM_THREADS-1:0]         blk_cmt,
  input  logic [NUM_THREADS-1:0]         unblk_cmt,
  input  logic [NUM_THREADS-1:0]         cmt_squash,
  input  logic [NUM_THREADS*PC_W-1:0]    cmt_pc,
  input  logic [NUM_THREADS-1:0]         rob_squashing,
  input  logic [NUM_THREADS-1:0]         dec_squash,
  input  logic [NUM_THREADS*PC_W-1:0]    dec_pc,
  input  logic [NUM_THREADS-1:0]         line_req_sent,
  input  logic [NUM_THREADS-1:0]         line_req_refused,
  input  logic                           retry_sent,
  input  logic [NUM_THREADS-1:0]         line_resp,
  input  logic [NUM_THREADS-1:0]         line_fault,
  input  logic [NUM_THREADS-1:0]         line_quiesce,
  input  logic [NUM_THREADS-1:0]         fetch_grant,
  output logic [NUM_THREADS*STATE_W-1:0] thr_status,
  output logic                           stage_active,
  output logic [NUM_THREADS-1:0]         redirect_valid,
  output logic [NUM_THREADS*PC_W-1:0]    redirect_pc,
  output logic                           retry_busy,
  output logic [TID_W-1:0]               retry_owner
);
  logic [NUM_STAGES-1:0][NUM_THREADS-1:0] blk_all, unblk_all, stall_flags;
  logic [NUM_THREADS-1:0] stall_now, squashed, claim, retry_go;

  assign blk_all   = {blk_cmt, blk_exe, blk_ren, blk_dec};
  assign unblk_all = {unblk_cmt, unblk_exe, unblk_ren, unblk_dec};

  fsc_stall_flags #(.NUM_THREADS(NUM_THREADS)) u_flags (
    .clk(clk), .rst_n(rst_n), .blk(blk_all), .unblk(unblk_all),
    .flags_q(stall_flags), .stall_now(stall_now)
  );

  fsc_retry_slot #(.NUM_THREADS(NUM_THREADS)) u_slot (
    .clk(clk), .rst_n(rst_n), .claim(claim), .squashed(squashed),
    .retry_sent(retry_sent), .busy(retry_busy), .owner(retry_owner),
    .retry_go(retry_go)
  );

  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
    fsc_thread_fsm #(.PC_W(PC_W)) u_fsm (
      .clk(clk), .rst_n(rst_n),
      .cmt_sq(cmt_squash[t]), .cmt_tgt(cmt_pc[t*PC_W +: PC_W]),
      .rob_sq(rob_squashing[t]),
      .dec_sq(dec_squash[t]), .dec_tgt(dec_pc[t*PC_W +: PC_W]),
      .stall_now(stall_now[t]),
      .req_sent(line_req_sent[t]), .req_refused(line_req_refused[t]),
      .retry_go(retry_go[t]), .resp(line_resp[t]),
      .fault(line_fault[t]), .quiesce(line_quiesce[t]), .grant(fetch_grant[t]),
      .state(thr_status[t*STATE_W +: STATE_W]),
      .redir_valid(redirect_valid[t]),
      .redir_pc(redirect_pc[t*PC_W +: PC_W]),
      .squashed(squashed[t]), .claim(claim[t])
    );
  end

  always_comb begin
    stage_active = 1'b0;
    for (int t = 0; t < NUM_THREADS; t++)
      if (thr_active[t] && can_progress(thr_status[t*STATE_W +: STATE_W]))
        stage_active = 1'b1;
  end
endmodule

// File: rtl/fsc_checker.sv
module fsc_checker
  import fsc_pkg::*;
#(
  parameter int NUM_THREADS = 2,
  parameter int PC_W = 32
) (
  input logic                                   clk,
  input logic                                   rst_n,
  input logic [NUM_THREADS-1:0]                 thr_active,
  input logic [NUM_THREADS-1:0]                 blk_dec,
  input logic [NUM_THREADS-1:0]                 unblk_dec,
  input logic [NUM_THREADS-1:0]                 blk_ren,
  input logic [NUM_THREADS-1:0]                 unblk_ren,
  input logic [NUM_THREADS-1:0]                 blk_exe,
  input logic [NUM_THREADS-1:0]                 unblk_exe,
  input logic [NUM_THREADS-1:0]                 blk_cmt,
  input logic [NUM_THREADS-1:0]                 unblk_cmt,
  input logic [NUM_THREADS-1:0]                 cmt_squash,
  input logic [NUM_THREADS*PC_W-1:0]            cmt_pc,
  input logic [NUM_THREADS-1:0]                 rob_squashing,
  input logic [NUM_THREADS-1:0]                 dec_squash,
  input logic                                   retry_sent,
  input logic [NUM_THREADS-1:0]                 line_resp,
  input logic [NUM_THREADS*STATE_W-1:0]         thr_status,
  input logic                                   stage_active,
  input logic [NUM_THREADS*PC_W-1:0]            redirect_pc,
  input logic                                   retry_busy,
  input logic [NUM_STAGES-1:0][NUM_THREADS-1:0] stall_flags
);
  // R2
  unblock_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (((unblk_dec & (blk_dec | ~stall_flags[0])) |
      (unblk_ren & (blk_ren | ~stall_flags[1])) |
      (unblk_exe & (blk_exe | ~stall_flags[2])) |
      (unblk_cmt & (blk_cmt | ~stall_flags[3]))) == '0));

  // R8
  retry_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (retry_busy && retry_sent) |=> !retry_busy);

  // R13
  active_needs_thread_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stage_active |-> (thr_active != '0));

  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
    // R3
    cmt_squash_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmt_squash[t] |=> (thr_status[t*STATE_W +: STATE_W] == STATE_W'(TS_SQUASH)) &&
        (redirect_pc[t*PC_W +: PC_W] == $past(cmt_pc[t*PC_W +: PC_W])));

    // R4
    rob_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rob_squashing[t] && !cmt_squash[t]) |=>
        (thr_status[t*STATE_W +: STATE_W] == STATE_W'(TS_SQUASH)) &&
        $stable(redirect_pc[t*PC_W +: PC_W]));

    // R6
    wait_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((thr_status[t*STATE_W +: STATE_W] == STATE_W'(TS_WRESP)) && !cmt_squash[t] &&
       !rob_squashing[t] && !dec_squash[t] && !line_resp[t]) |=>
        (thr_status[t*STATE_W +: STATE_W] == STATE_W'(TS_WRESP)));

    // R12
    trap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((thr_status[t*STATE_W +: STATE_W] == STATE_W'(TS_TRAP)) && !cmt_squash[t] &&
       !rob_squashing[t] && !dec_squash[t]) |=>
        (thr_status[t*STATE_W +: STATE_W] == STATE_W'(TS_TRAP)));
  end
endmodule

bind fetch_status_ctrl fsc_checker #(.NUM_THREADS(NUM_THREADS), .PC_W(PC_W)) chk_i (.*);

// File: tb/fetch_status_ctrl_tb.sv
module fetch_status_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NT = 2;
  localparam int PW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NT-1:0] thr_active, blk_dec, unblk_dec, blk_ren, unblk_ren, blk_exe, unblk_exe;
  logic [NT-1:0] blk_cmt, unblk_cmt, cmt_squash, rob_squashing, dec_squash;
  logic [NT-1:0] line_req_sent, line_req_refused, line_resp, line_fault, line_quiesce, fetch_grant;
  logic retry_sent;
  logic [NT*PW-1:0] cmt_pc, dec_pc, redirect_pc;
  logic [NT*4-1:0] thr_status;
  logic stage_active, retry_busy;
  logic [NT-1:0] redirect_valid;
  logic [0:0] retry_owner;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fetch_status_ctrl #(.NUM_THREADS(NT), .PC_W(PW)) dut_i (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] st(input int t);
    return thr_status[t*4 +: 4];
  endfunction

  function automatic logic [31:0] rpc(input int t);
    return redirect_pc[t*PW +: PW];
  endfunction

  task automatic clr();
    {blk_dec, unblk_dec, blk_ren, unblk_ren, blk_exe, unblk_exe, blk_cmt, unblk_cmt} = '0;
    {cmt_squash, rob_squashing, dec_squash, line_req_sent, line_req_refused} = '0;
    {line_resp, line_fault, line_quiesce, fetch_grant} = '0;
    retry_sent = 1'b0;
  endtask

  task automatic tick();
    @(negedge clk);
    clr();
  endtask

  task automatic t_reset();
    chk("R1 status t0", st(0), 0);
    chk("R1 status t1", st(1), 0);
    chk("R1 retry slot", retry_busy, 0);
    chk("R1 redirect strobe", redirect_valid, 0);
    chk("R1 redirect pc", rpc(0), 0);
  endtask

  task automatic t_stall();
    thr_active = 2'b01;
    blk_dec[0] = 1; tick();
    chk("R2 block pulse", st(0), 3);
    chk("R13 blocked inactive", stage_active, 0);
    chk("R2 other thread", st(1), 0);
    tick();
    chk("R2 sticky", st(0), 3);
    blk_ren[0] = 1; tick();
    unblk_dec[0] = 1; tick();
    chk("R2 rename still set", st(0), 3);
    unblk_ren[0] = 1; tick();
    chk("R7 unblock all", st(0), 0);
    chk("R13 running active", stage_active, 1);
    thr_active = 2'b11;
  endtask

  task automatic t_fetch();
    line_req_sent[0] = 1; tick();
    chk("R8 request sent", st(0), 4);
    line_resp[0] = 1; tick();
    chk("R9 response", st(0), 6);
    tick();
    chk("R10 hold without grant", st(0), 6);
    fetch_grant[0] = 1; tick();
    chk("R10 grant", st(0), 0);
    line_req_sent[0] = 1; tick();
    blk_exe[0] = 1; tick();
    chk("R6 wait ignores stall", st(0), 4);
    line_resp[0] = 1; tick();
    chk("R9 response while stalled", st(0), 3);
    unblk_exe[0] = 1; tick();
    chk("R7 back to running", st(0), 0);
    line_resp[0] = 1; tick();
    chk("R9 stray response", st(0), 0);
  endtask

  task automatic t_retry();
    line_req_refused[0] = 1; tick();
    chk("R8 refused state", st(0), 5);
    chk("R8 slot claimed", retry_busy, 1);
    chk("R8 slot owner", retry_owner, 0);
    blk_cmt[0] = 1; tick();
    chk("R6 retry ignores stall", st(0), 5);
    unblk_cmt[0] = 1; tick();
    retry_sent = 1; tick();
    chk("R8 retry sent", st(0), 4);
    chk("R8 slot freed", retry_busy, 0);
    line_resp[0] = 1; tick();
    fetch_grant[0] = 1; tick();
    chk("R10 after retry", st(0), 0);
  endtask

  task automatic t_priority();
    cmt_squash[0] = 1; cmt_pc[31:0] = 32'h100;
    dec_squash[0] = 1; dec_pc[31:0] = 32'h200;
    rob_squashing[0] = 1; blk_dec[0] = 1; tick();
    chk("R3 commit squash state", st(0), 2);
    chk("R3 commit target", rpc(0), 32'h100);
    chk("R3 strobe", redirect_valid[0], 1);
    tick();
    chk("R6 squashing then stall", st(0), 3);
    chk("R3 strobe one cycle", redirect_valid[0], 0);
    unblk_dec[0] = 1; tick();
    chk("R7 blocked to running", st(0), 0);
  endtask

  task automatic t_rob();
    cmt_squash[0] = 1; cmt_pc[31:0] = 32'h300; tick();
    rob_squashing[0] = 1; dec_squash[0] = 1; dec_pc[31:0] = 32'h400; tick();
    chk("R4 rob holds", st(0), 2);
    chk("R4 target kept", rpc(0), 32'h300);
    chk("R4 no strobe", redirect_valid[0], 0);
    dec_squash[0] = 1; dec_pc[31:0] = 32'h450; tick();
    chk("R5 decode ignored when squashing", rpc(0), 32'h300);
    chk("R5 no strobe", redirect_valid[0], 0);
    chk("R7 squashing to running", st(0), 0);
    dec_squash[0] = 1; dec_pc[31:0] = 32'h500; tick();
    chk("R5 decode squash", st(0), 2);
    chk("R5 decode target", rpc(0), 32'h500);
    chk("R5 strobe", redirect_valid[0], 1);
    tick();
  endtask

  task automatic t_cancel();
    line_req_sent[0] = 1; tick();
    cmt_squash[0] = 1; cmt_pc[31:0] = 32'h600; tick();
    chk("R11 squash in wait", st(0), 2);
    line_resp[0] = 1; tick();
    chk("R11 late response dropped", st(0), 0);
    line_req_refused[1] = 1; tick();
    chk("R11 t1 owns slot", retry_owner, 1);
    dec_squash[0] = 1; dec_pc[31:0] = 32'h680; tick();
    chk("R11 other squash keeps slot", retry_busy, 1);
    cmt_squash[1] = 1; cmt_pc[63:32] = 32'h690; tick();
    chk("R11 owner squash frees slot", retry_busy, 0);
    chk("R11 owner squashing", st(1), 2);
    tick();
  endtask

  task automatic t_trap();
    line_fault[0] = 1; tick();
    chk("R12 fault", st(0), 7);
    blk_exe[0] = 1; tick();
    chk("R12 trap ignores stall", st(0), 7);
    unblk_exe[0] = 1; line_resp[0] = 1; tick();
    fetch_grant[0] = 1; tick();
    chk("R12 trap ignores grant", st(0), 7);
    dec_squash[0] = 1; dec_pc[31:0] = 32'h700; tick();
    chk("R12 squash leaves trap", st(0), 2);
    tick();
    line_quiesce[0] = 1; tick();
    chk("R12 quiesce", st(0), 8);
    tick();
    chk("R12 quiesce holds", st(0), 8);
    cmt_squash[0] = 1; cmt_pc[31:0] = 32'h800; tick();
    chk("R12 squash leaves quiesce", st(0), 2);
    tick();
  endtask

  task automatic t_active();
    thr_active = 2'b00; #1;
    chk("R13 no threads enabled", stage_active, 0);
    thr_active = 2'b10; #1;
    chk("R13 t1 running", stage_active, 1);
    thr_active = 2'b01;
    line_req_sent[0] = 1; tick();
    chk("R13 waiting thread", stage_active, 0);
    line_resp[0] = 1; tick();
    chk("R13 access complete", stage_active, 1);
    fetch_grant[0] = 1; tick();
    thr_active = 2'b11;
  endtask

  initial begin
    thr_active = 2'b11; cmt_pc = '0; dec_pc = '0;
    clr();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_stall();
    t_fetch();
    t_retry();
    t_priority();
    t_rob();
    t_cancel();
    t_trap();
    t_active();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end
endmodule